// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits on the host side of a byte-wide asynchronous static RAM. It turns single-beat requests from synchronous logic into correctly timed pin activity on the memory. The memory side has a 19-bit address, an 8-bit bidirectional data bus and three active-low strobes: chip select, output enable and write strobe. The host presents a request with a write flag, an address and write data while `ready` is high. Some cycles later it sees a one-clock `done` pulse. After a read, the returned byte is on `rdData`.

All memory timing is counted in clock cycles. Each limit is a parameter in nanoseconds, and a ceiling division by the clock period turns it into a cycle count. A read holds chip select and output enable low for the longest of the address, chip-select and output-enable access times. A write holds chip select and the write strobe low together for a counted pulse, with output enable held high. It then raises the write strobe while keeping chip select, address and data for a hold count. Every access ends with chip select high for a recovery count before the next request can be accepted.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While reset is asserted and in the first idle cycle after it, `memCeN`, `memOeN` and `memWeN` are high, `ready` is high and `done` is low.
- R2: An accepted read (`reqWrite`=0) drives `memCeN` and `memOeN` low with `memWeN` high for exactly ceil(70/period) cycles, which is 4 at a 20 ns clock. The byte on `memDq` in the last of those cycles appears on `rdData`.
- R3: An accepted write (`reqWrite`=1) drives `memWeN` low for exactly ceil(55/period) cycles, which is 3 at 20 ns. `memOeN` is high whenever `memWeN` is low.
- R4: The controller drives `memDq` only while `memWeN` is low and during the hold cycle that follows. It never drives the bus while `memOeN` is low. Written bytes therefore land in memory and read back intact.
- R5: `memAddr` equals the accepted request address and stays unchanged for every cycle that `memCeN` is low.
- R6: `ready` is low from the accepting clock edge until recovery ends. A request raised while `ready` is low starts no memory cycle and writes nothing.
- R7: Between two accesses, `memCeN` stays high for at least the recovery count, ceil(15/period) cycles, which is 1 at 20 ns.
- R8: Each accepted request produces exactly one single-cycle `done` pulse. It rises 5 clock edges after the accepting edge at the default timing. `rdData` keeps its last read value across writes.
- R9: For a write, `memCeN` stays low for at least ceil(70/period) cycles: the write pulse plus one address/data hold cycle, 4 in total at 20 ns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request strobe, taken when `ready` is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 19 | Request address |
| reqWdata | input | 8 | Write data |
| ready | output | 1 | Controller idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 8 | Last byte read |
| memAddr | output | 19 | Memory address pins |
| memCeN | output | 1 | Memory chip select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memDq | inout | 8 | Memory data bus |

## Verification
All memory pins come from registers, so an access begins on the first cycle after the accepting edge. At a 20 ns clock, `done` and a fresh `rdData` are due after the fifth edge for both reads and writes, and `ready` returns one edge later. The bench samples on the falling clock edge, counts cycles from the accepting edge, and checks `done`, `ready` and `rdData` at exactly those counts. A falling-edge pin monitor measures how long each strobe stays low and how long chip select stays high between accesses. It compares those run lengths with the cycle counts stated in the requirements.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  function automatic int ceilDiv(input int ns, input int periodNs);
    return (ns + periodNs - 1) / periodNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_WPULSE,
    ST_WHOLD,
    ST_RECOV
  } ctrlState_t;

  typedef struct packed {
    logic latchReq;
    logic capture;
    logic driveBus;
  } dpStrobe_t;

endpackage

// File: rtl/sram_ctrl_datapath.sv
module sram_ctrl_datapath
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] dqIn,
  output logic [ADDR_W-1:0] addrOut,
  output logic [DATA_W-1:0] dqOut,
  output logic              dqOe,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;
  logic              dqOeQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobe.latchReq) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdataQ <= '0;
    end else if (strobe.capture) begin
      rdataQ <= dqIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dqOeQ <= 1'b0;
    end else begin
      dqOeQ <= strobe.driveBus;
    end
  end

  assign addrOut = addrQ;
  assign dqOut   = wdataQ;
  assign dqOe    = dqOeQ;
  assign rdData  = rdataQ;

  AST_WDATA_STABLE_WHILE_DRIVEN: assert property (@(posedge clk) disable iff (!rstN)
    dqOeQ && $past(dqOeQ) |-> $stable(wdataQ)) else $error("write data moved while driven"); // R4

endmodule

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYC   = 4,
  parameter int WP_CYC   = 3,
  parameter int HOLD_CYC = 1,
  parameter int REC_CYC  = 1,
  parameter int CNT_W    = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  output logic      ready,
  output logic      done,
  output logic      ceN,
  output logic      oeN,
  output logic      weN,
  output dpStrobe_t strobe
);

  localparam logic [CNT_W-1:0] RD_LOAD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_LOAD   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LOAD = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] REC_LOAD  = CNT_W'(REC_CYC - 1);

  ctrlState_t       state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic             doneNext;
  logic             ceNQ, oeNQ, weNQ, doneQ;

  always_comb begin
    nextState = state;
    nextCnt   = cnt;
    doneNext  = 1'b0;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.latchReq = 1'b1;
          nextState = reqWrite ? ST_WPULSE : ST_READ;
          nextCnt   = reqWrite ? WP_LOAD : RD_LOAD;
        end
      end
      ST_READ: begin
        if (cnt == '0) begin
          strobe.capture = 1'b1;
          doneNext  = 1'b1;
          nextState = ST_RECOV;
          nextCnt   = REC_LOAD;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_WPULSE: begin
        if (cnt == '0) begin
          nextState = ST_WHOLD;
          nextCnt   = HOLD_LOAD;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_WHOLD: begin
        if (cnt == '0) begin
          doneNext  = 1'b1;
          nextState = ST_RECOV;
          nextCnt   = REC_LOAD;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      ST_RECOV: begin
        if (cnt == '0) begin
          nextState = ST_IDLE;
        end else begin
          nextCnt = cnt - 1'b1;
        end
      end
      default: nextState = ST_IDLE;
    endcase
    strobe.driveBus = (nextState == ST_WPULSE) || (nextState == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
      ceNQ  <= 1'b1;
      oeNQ  <= 1'b1;
      weNQ  <= 1'b1;
      doneQ <= 1'b0;
    end else begin
      state <= nextState;
      cnt   <= nextCnt;
      ceNQ  <= !((nextState == ST_READ) || (nextState == ST_WPULSE) || (nextState == ST_WHOLD));
      oeNQ  <= !(nextState == ST_READ);
      weNQ  <= !(nextState == ST_WPULSE);
      doneQ <= doneNext;
    end
  end

  assign ready = (state == ST_IDLE);
  assign done  = doneQ;
  assign ceN   = ceNQ;
  assign oeN   = oeNQ;
  assign weN   = weNQ;

  // Run-length counters used only by the pin-timing properties
  logic [CNT_W-1:0] weLowRun, ceHighRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      weLowRun  <= '0;
      ceHighRun <= '0;
    end else begin
      if (!weNQ) weLowRun <= (weLowRun == '1) ? weLowRun : weLowRun + 1'b1;
      else       weLowRun <= '0;
      if (ceNQ)  ceHighRun <= (ceHighRun == '1) ? ceHighRun : ceHighRun + 1'b1;
      else       ceHighRun <= '0;
    end
  end

  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    !weNQ |-> oeNQ) else $error("output enable low during write"); // R3
  AST_WE_PULSE_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(weNQ) |-> (weLowRun >= CNT_W'(WP_CYC))) else $error("write pulse too short"); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ) else $error("done wider than one cycle"); // R8
  AST_READY_DESELECTED: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> ceNQ) else $error("ready while selected"); // R6
  AST_CE_RECOVERY: assert property (@(posedge clk) disable iff (!rstN)
    $fell(ceNQ) |-> (ceHighRun >= CNT_W'(REC_CYC))) else $error("recovery too short"); // R7

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 20,
  parameter int T_AA_NS       = 70,
  parameter int T_ACE_NS      = 70,
  parameter int T_OE_NS       = 35,
  parameter int T_WP_NS       = 55,
  parameter int T_DW_NS       = 30,
  parameter int T_WC_NS       = 70,
  parameter int T_DH_NS       = 0,
  parameter int T_AH_NS       = 5,
  parameter int T_REC_NS      = 15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              ready,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  inout  wire  [DATA_W-1:0] memDq
);

  localparam int RD_CYC = maxOf(1, maxOf(ceilDiv(T_AA_NS, CLK_PERIOD_NS),
                          maxOf(ceilDiv(T_ACE_NS, CLK_PERIOD_NS), ceilDiv(T_OE_NS, CLK_PERIOD_NS))));
  localparam int HOLD_CYC = maxOf(1, maxOf(ceilDiv(T_DH_NS, CLK_PERIOD_NS), ceilDiv(T_AH_NS, CLK_PERIOD_NS)));
  localparam int WP_CYC = maxOf(1, maxOf(maxOf(ceilDiv(T_WP_NS, CLK_PERIOD_NS), ceilDiv(T_DW_NS, CLK_PERIOD_NS)),
                          ceilDiv(T_WC_NS, CLK_PERIOD_NS) - HOLD_CYC));
  localparam int REC_CYC = maxOf(1, ceilDiv(T_REC_NS, CLK_PERIOD_NS));
  localparam int MAX_CYC = maxOf(maxOf(RD_CYC, WP_CYC), maxOf(HOLD_CYC, REC_CYC));
  localparam int CNT_W   = $clog2(MAX_CYC + 1) + 1;

  dpStrobe_t         strobe;
  logic [DATA_W-1:0] dqOut;
  logic              dqOe;

  sram_ctrl_fsm #(
    .RD_CYC(RD_CYC), .WP_CYC(WP_CYC), .HOLD_CYC(HOLD_CYC), .REC_CYC(REC_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .ready(ready), .done(done), .ceN(memCeN), .oeN(memOeN), .weN(memWeN), .strobe(strobe)
  );

  sram_ctrl_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .dqIn(memDq), .addrOut(memAddr), .dqOut(dqOut), .dqOe(dqOe), .rdData(rdData)
  );

  assign memDq = dqOe ? dqOut : {DATA_W{1'bz}};

  AST_NO_CONTENTION: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> memOeN) else $error("host drives bus with output enable low"); // R4
  AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !memCeN && $past(!memCeN) |-> $stable(memAddr)) else $error("address moved during access"); // R5
  AST_DRIVE_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    dqOe |-> !memCeN) else $error("bus driven while deselected"); // R4

endmodule

// File: tb/sram_cycle_ctrl_bench.sv
module sram_cycle_ctrl_bench;

  localparam int EXP_RD_LOW = 4;  // R2
  localparam int EXP_WE_LOW = 3;  // R3
  localparam int EXP_WR_CE  = 4;  // R9
  localparam int EXP_REC    = 1;  // R7
  localparam int EXP_DONE   = 5;  // R8
  localparam int NVEC       = 9;

  // {write, address, data}
  localparam logic [27:0] VEC [NVEC] = '{
    {1'b1, 19'h00000, 8'h3C},
    {1'b0, 19'h00000, 8'h00},
    {1'b1, 19'h7FFFF, 8'hC3},
    {1'b0, 19'h7FFFF, 8'h00},
    {1'b0, 19'h00012, 8'h00},
    {1'b1, 19'h2AB55, 8'hFF},
    {1'b1, 19'h55500, 8'h00},
    {1'b0, 19'h2AB55, 8'h00},
    {1'b0, 19'h00000, 8'h00}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [18:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        ready, done;
  logic [7:0]  rdData;
  logic [18:0] memAddr;
  logic        memCeN, memOeN, memWeN;
  wire  [7:0]  memDq;

  int checks = 0;
  int fails  = 0;
  logic [7:0]  mem    [256];
  logic [7:0]  shadow [256];
  logic [18:0] expAddr = '0;

  always #10 clk = ~clk;

  sram_cycle_ctrl u_sram_cycle_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .ready(ready), .done(done), .rdData(rdData), .memAddr(memAddr),
    .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN), .memDq(memDq)
  );

  // Zero-delay memory model
  assign memDq = (!memCeN && !memOeN && memWeN) ? mem[memAddr[7:0]] : 8'hzz;
  always @(posedge memWeN) if (rstN && !memCeN) mem[memAddr[7:0]] = memDq;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Pin monitor
  int  ceLow = 0, weLow = 0, ceHigh = 0;
  bit  sawWrite = 0;
  bit  prevCe = 1;
  always @(negedge clk) begin
    if (rstN) begin
      if (!memCeN && prevCe) check(ceHigh >= EXP_REC, "R7", ceHigh, EXP_REC);
      if (!memCeN) begin
        ceLow++;
        check(memAddr == expAddr, "R5", memAddr, expAddr);
        if (!memWeN) begin
          weLow++;
          sawWrite = 1;
          check(memOeN == 1'b1, "R3", memOeN, 1);
        end
        ceHigh = 0;
      end else begin
        ceHigh++;
        if (!prevCe) begin
          if (sawWrite) begin
            check(ceLow >= EXP_WR_CE, "R9", ceLow, EXP_WR_CE);
            check(weLow == EXP_WE_LOW, "R3", weLow, EXP_WE_LOW);
          end else begin
            check(ceLow == EXP_RD_LOW, "R2", ceLow, EXP_RD_LOW);
          end
          ceLow = 0; weLow = 0; sawWrite = 0;
        end
      end
      prevCe = memCeN;
    end
  end

  task automatic doOp(input bit wr, input logic [18:0] addr, input logic [7:0] data);
    int cyc;
    while (!ready) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqWdata = data;
    expAddr = addr;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    cyc = 1;
    while (!done && cyc < 40) begin
      @(negedge clk);
      cyc++;
    end
    check(cyc == EXP_DONE, "R8", cyc, EXP_DONE);
    check(ready == 1'b0, "R6", ready, 0);
    if (wr) shadow[addr[7:0]] = data;
    else    check(rdData == shadow[addr[7:0]], wr ? "R4" : "R2", rdData, shadow[addr[7:0]]);
    @(negedge clk);
    check(done == 1'b0, "R8", done, 0);
    check(ready == 1'b1, "R6", ready, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] keep;
    for (int i = 0; i < 256; i++) begin
      mem[i]    = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(memCeN && memOeN && memWeN, "R1", {memCeN, memOeN, memWeN}, 3'b111);
    check(done == 1'b0, "R1", done, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(ready == 1'b1, "R1", ready, 1);
    check(memCeN && memOeN && memWeN, "R1", {memCeN, memOeN, memWeN}, 3'b111);

    // Vector table (R2, R3, R4, R5, R9)
    for (int v = 0; v < NVEC; v++) begin
      doOp(VEC[v][27], VEC[v][26:8], VEC[v][7:0]);
    end

    // R8: rdData held across a write
    keep = rdData;
    doOp(1'b1, 19'h00077, 8'h99);
    check(rdData == keep, "R8", rdData, keep);

    // R6: request while busy is ignored
    while (!ready) @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b0; reqAddr = 19'h00040; expAddr = 19'h00040;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 19'h00041; reqWdata = 8'hEE;
    @(negedge clk);
    reqValid = 1'b0;
    while (!done) @(negedge clk);
    check(rdData == shadow[8'h40], "R6", rdData, shadow[8'h40]);
    repeat (4) @(negedge clk);
    check(memCeN == 1'b1, "R6", memCeN, 1);
    check(done == 1'b0, "R6", done, 0);
    doOp(1'b0, 19'h00041, 8'h00);
    check(rdData == (8'h41 ^ 8'h5A), "R6", rdData, 8'h41 ^ 8'h5A);

    // R7: back-to-back write then read
    doOp(1'b1, 19'h12345, 8'h6D);
    doOp(1'b0, 19'h12345, 8'h00);
    check(rdData == 8'h6D, "R4", rdData, 8'h6D);

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule